// File: doc/BRIEF.md
# Multi-Channel PCM Time Slot Assigner

This block produces the per-channel frame sync strobes for four codec channels that share one PCM bus. It counts bit clocks from an external frame sync pulse to track the current 8-bit time slot. A frame holds at most 64 slots. Each channel holds one transmit and one receive slot assignment, and each assignment has its own enable flag. When a channel's enabled assignment matches the current slot, the block drives that channel's strobe high for the whole slot. A shared active-low flag shows that some transmit strobe is active.

Assignments arrive as 8-bit words on a three-wire serial control port: a data line, a control clock and an active-low select. The target channel is taken from a 2-bit channel select input. Both the control clock and the select are sampled in the bit-clock domain. Each loaded word first goes into a pending register. The pending values move into the active set only at a frame sync, so a strobe that is in progress is never cut short by a reload.

Top module: `pcm_slot_assigner`

## Requirements
- R1: The edge that samples `frame_sync_i` high restarts the count at slot 0, bit 0. Every slot then lasts 8 bit clocks, and slot n starts 8*n clocks after that edge.
- R2: A control word is shifted in most significant bit first, one bit per rising edge of `ctl_clk_i`. Its fields are: bit 7 for direction (0 = transmit, 1 = receive), bit 6 for enable, and bits 5:0 for the slot number. The target channel is the value of `chan_sel_i` at the moment `ctl_sel_n_i` is released.
- R3: Control clock edges count only while `ctl_sel_n_i` is low. A word is stored only if exactly 8 edges arrived before the release. Any other count leaves every assignment unchanged.
- R4: A strobe is high for exactly 8 consecutive bit clocks in each frame in which its enabled assignment matches, and it is low for the rest of the frame.
- R5: The transmit and receive assignments of a channel are independent, so a channel may pulse in one direction only.
- R6: `tx_busy_n_o` is low for exactly those bit clocks in which at least one transmit strobe is high. Two channels sharing a transmit slot give a single 8-clock low period.
- R7: A word loaded during a frame does not change that frame's strobes. It takes effect from the next frame sync.
- R8: After reset, every assignment is disabled, all strobes are low and `tx_busy_n_o` is high.
- R9: No strobe is raised before the first frame sync, nor after slot 63 ends and before the next frame sync.
- R10: An assignment whose enable bit is 0 produces no strobe, whatever slot number it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock of the PCM bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | External frame start, sampled high for one bit clock |
| ctl_clk_i | input | 1 | Serial control clock, sampled in the bit-clock domain |
| ctl_data_i | input | 1 | Serial control data, most significant bit first |
| ctl_sel_n_i | input | 1 | Active-low select of the control port |
| chan_sel_i | input | 2 | Channel that a word targets, taken at select release |
| tx_fs_o | output | 4 | Transmit frame sync, one bit per channel |
| rx_fs_o | output | 4 | Receive frame sync, one bit per channel |
| tx_busy_n_o | output | 1 | Low while any transmit strobe is active |

## Verification
The hardest case to reach from the ports is a word that lands while a frame is running and targets a slot that has not yet come in that frame. Only that timing separates a double-buffered assignment from one that is applied at once. The bench reaches it by starting a serial load in parallel with a frame that is already counting. The load completes well before the old slot arrives and rewrites the assignment to a slot earlier in the frame. The bench then expects the old position in that frame and the new one in the following frame. Words of 7 and 9 bits, and control clock edges given while the select is high, are followed by a full frame so that any corrupted assignment would show up on the strobes.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } tsa_dir_e;

endpackage

// File: rtl/pcm_tsa_serial_loader.sv
module pcm_tsa_serial_loader #(
  parameter int WORD_W = 8,
  parameter int CH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_clk_i,
  input  logic              ctl_data_i,
  input  logic              ctl_sel_n_i,
  input  logic [CH_W-1:0]   chan_sel_i,
  output logic              wr_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic [CH_W-1:0]   wr_chan_o
);

  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_SAT = WORD_W + 1;

  logic              ctl_clk_q;
  logic              sel_n_q;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              shift_en;
  logic              release_evt;

  // a rising control clock seen while the port is selected
  assign shift_en    = ctl_clk_i & ~ctl_clk_q & ~ctl_sel_n_i;
  assign release_evt = ctl_sel_n_i & ~sel_n_q;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (shift_en) begin
      shreg_d = {shreg_q[WORD_W-2:0], ctl_data_i};
      if (cnt_q != CNT_W'(CNT_SAT)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (ctl_sel_n_i) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_clk_q <= 1'b0;
      sel_n_q   <= 1'b1;
      cnt_q     <= '0;
    end else begin
      ctl_clk_q <= ctl_clk_i;
      sel_n_q   <= ctl_sel_n_i;
      cnt_q     <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
    end else if (shift_en) begin
      shreg_q <= shreg_d;
    end
  end

  assign wr_o      = release_evt & (cnt_q == CNT_W'(WORD_W));
  assign wr_word_o = shreg_q;
  assign wr_chan_o = chan_sel_i;

endmodule

// File: rtl/pcm_tsa_frame_timer.sv
module pcm_tsa_frame_timer #(
  parameter int SLOT_W        = 6,
  parameter int BITS_PER_SLOT = 8,
  localparam int BIT_W = (BITS_PER_SLOT > 1) ? $clog2(BITS_PER_SLOT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_sync_i,
  output logic              running_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o
);

  localparam int LAST_BIT  = BITS_PER_SLOT - 1;
  localparam int LAST_SLOT = (2 ** SLOT_W) - 1;

  logic              running_q, running_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              tick_en;
  logic              slot_end;

  assign tick_en  = frame_sync_i | running_q;
  assign slot_end = (bit_q == BIT_W'(LAST_BIT));

  always_comb begin
    running_d = running_q;
    slot_d    = slot_q;
    bit_d     = bit_q;
    if (frame_sync_i) begin
      running_d = 1'b1;
      slot_d    = '0;
      bit_d     = '0;
    end else if (running_q) begin
      if (slot_end) begin
        bit_d = '0;
        if (slot_q == SLOT_W'(LAST_SLOT)) begin
          running_d = 1'b0;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      slot_q    <= '0;
      bit_q     <= '0;
    end else if (tick_en) begin
      running_q <= running_d;
      slot_q    <= slot_d;
      bit_q     <= bit_d;
    end
  end

  assign running_o = running_q;
  assign slot_o    = slot_q;
  assign bit_o     = bit_q;

endmodule

// File: rtl/pcm_tsa_assign_bank.sv
module pcm_tsa_assign_bank
  import pcm_tsa_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 6,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ENT_W  = SLOT_W + 1,
  localparam int WORD_W = SLOT_W + 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [WORD_W-1:0]             wr_word_i,
  input  logic [CH_W-1:0]               wr_chan_i,
  input  logic                          load_i,
  output logic [NUM_CH-1:0][ENT_W-1:0]  pend_tx_o,
  output logic [NUM_CH-1:0][ENT_W-1:0]  pend_rx_o,
  output logic [NUM_CH-1:0][ENT_W-1:0]  act_tx_o,
  output logic [NUM_CH-1:0][ENT_W-1:0]  act_rx_o
);

  tsa_dir_e          wr_dir;
  logic [ENT_W-1:0]  wr_entry;

  assign wr_dir   = tsa_dir_e'(wr_word_i[WORD_W-1]);
  assign wr_entry = {wr_word_i[WORD_W-2], wr_word_i[SLOT_W-1:0]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    logic tx_we, rx_we;

    assign hit   = wr_i & (wr_chan_i == CH_W'(c));
    assign tx_we = hit & (wr_dir == DIR_TX);
    assign rx_we = hit & (wr_dir == DIR_RX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_tx_o[c] <= '0;
      end else if (tx_we) begin
        pend_tx_o[c] <= wr_entry;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_rx_o[c] <= '0;
      end else if (rx_we) begin
        pend_rx_o[c] <= wr_entry;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_tx_o[c] <= '0;
        act_rx_o[c] <= '0;
      end else if (load_i) begin
        act_tx_o[c] <= pend_tx_o[c];
        act_rx_o[c] <= pend_rx_o[c];
      end
    end
  end

endmodule

// File: rtl/pcm_slot_assigner.sv
module pcm_slot_assigner #(
  parameter int NUM_CH        = 4,
  parameter int SLOT_W        = 6,
  parameter int BITS_PER_SLOT = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_sync_i,
  input  logic              ctl_clk_i,
  input  logic              ctl_data_i,
  input  logic              ctl_sel_n_i,
  input  logic [CH_W-1:0]   chan_sel_i,
  output logic [NUM_CH-1:0] tx_fs_o,
  output logic [NUM_CH-1:0] rx_fs_o,
  output logic              tx_busy_n_o
);

  localparam int WORD_W = SLOT_W + 2;
  localparam int ENT_W  = SLOT_W + 1;
  localparam int BIT_W  = (BITS_PER_SLOT > 1) ? $clog2(BITS_PER_SLOT) : 1;

  logic [1:0]                    rst_sync_q;
  logic                          rst_n_int;
  logic                          wr_w;
  logic [WORD_W-1:0]             wr_word_w;
  logic [CH_W-1:0]               wr_chan_w;
  logic                          running_w;
  logic [SLOT_W-1:0]             slot_w;
  logic [BIT_W-1:0]              bit_w;
  logic [NUM_CH-1:0][ENT_W-1:0]  pend_tx_w, pend_rx_w;
  logic [NUM_CH-1:0][ENT_W-1:0]  act_tx_w, act_rx_w;
  logic [2*NUM_CH*ENT_W-1:0]     act_flat_w;
  logic [2*NUM_CH*ENT_W-1:0]     pend_flat_w;

  // reset asserts at once and leaves two bit clocks later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  pcm_tsa_serial_loader #(
    .WORD_W (WORD_W),
    .CH_W   (CH_W)
  ) u_loader (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .ctl_clk_i   (ctl_clk_i),
    .ctl_data_i  (ctl_data_i),
    .ctl_sel_n_i (ctl_sel_n_i),
    .chan_sel_i  (chan_sel_i),
    .wr_o        (wr_w),
    .wr_word_o   (wr_word_w),
    .wr_chan_o   (wr_chan_w)
  );

  pcm_tsa_frame_timer #(
    .SLOT_W        (SLOT_W),
    .BITS_PER_SLOT (BITS_PER_SLOT)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .frame_sync_i (frame_sync_i),
    .running_o    (running_w),
    .slot_o       (slot_w),
    .bit_o        (bit_w)
  );

  pcm_tsa_assign_bank #(
    .NUM_CH (NUM_CH),
    .SLOT_W (SLOT_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .wr_i      (wr_w),
    .wr_word_i (wr_word_w),
    .wr_chan_i (wr_chan_w),
    .load_i    (frame_sync_i),
    .pend_tx_o (pend_tx_w),
    .pend_rx_o (pend_rx_w),
    .act_tx_o  (act_tx_w),
    .act_rx_o  (act_rx_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign tx_fs_o[c] = running_w & act_tx_w[c][ENT_W-1]
                        & (act_tx_w[c][SLOT_W-1:0] == slot_w);
    assign rx_fs_o[c] = running_w & act_rx_w[c][ENT_W-1]
                        & (act_rx_w[c][SLOT_W-1:0] == slot_w);
  end

  assign tx_busy_n_o = ~|tx_fs_o;

  assign act_flat_w  = {act_rx_w, act_tx_w};
  assign pend_flat_w = {pend_rx_w, pend_tx_w};

endmodule

// File: rtl/pcm_slot_assigner_chk.sv
module pcm_slot_assigner_chk #(
  parameter int NUM_CH        = 4,
  parameter int SLOT_W        = 6,
  parameter int BITS_PER_SLOT = 8,
  localparam int ENT_W  = SLOT_W + 1,
  localparam int FLAT_W = 2 * NUM_CH * ENT_W,
  localparam int BIT_W  = (BITS_PER_SLOT > 1) ? $clog2(BITS_PER_SLOT) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_sync_i,
  input logic              ctl_sel_n_i,
  input logic [NUM_CH-1:0] tx_fs_o,
  input logic [NUM_CH-1:0] rx_fs_o,
  input logic              running_w,
  input logic [SLOT_W-1:0] slot_w,
  input logic [BIT_W-1:0]  bit_w,
  input logic [FLAT_W-1:0] act_flat_w,
  input logic [FLAT_W-1:0] pend_flat_w
);

  localparam int RUN_W     = $clog2(BITS_PER_SLOT + 2);
  localparam int RUN_SAT   = BITS_PER_SLOT + 1;
  localparam int LAST_BIT  = BITS_PER_SLOT - 1;
  localparam int LAST_SLOT = (2 ** SLOT_W) - 1;

  logic [2*NUM_CH-1:0] fs_all;
  assign fs_all = {rx_fs_o, tx_fs_o};

  for (genvar k = 0; k < 2 * NUM_CH; k++) begin : g_run
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q <= '0;
      end else if (frame_sync_i || !fs_all[k]) begin
        run_q <= '0;
      end else if (run_q != RUN_W'(RUN_SAT)) begin
        run_q <= run_q + 1'b1;
      end
    end
    AST_FS_MAX_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= RUN_W'(BITS_PER_SLOT)); // R4
  end

  AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_w |-> (fs_all == '0)); // R9

  AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i |=> (running_w && slot_w == '0 && bit_w == '0)); // R1

  AST_SLOT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_w && !frame_sync_i && bit_w == BIT_W'(LAST_BIT) && slot_w != SLOT_W'(LAST_SLOT))
    |=> (slot_w == SLOT_W'($past(slot_w) + 1'b1))); // R1

  AST_STROBE_STABLE_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_w && !frame_sync_i && bit_w != BIT_W'(LAST_BIT)) |=> $stable(fs_all)); // R4

  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_sync_i |=> $stable(act_flat_w)); // R7

  AST_NO_WRITE_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_sel_n_i ##1 ctl_sel_n_i) |=> $stable(pend_flat_w)); // R3

endmodule

bind pcm_slot_assigner pcm_slot_assigner_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_sync_i (frame_sync_i),
  .ctl_sel_n_i  (ctl_sel_n_i),
  .tx_fs_o      (tx_fs_o),
  .rx_fs_o      (rx_fs_o),
  .running_w    (running_w),
  .slot_w       (slot_w),
  .bit_w        (bit_w),
  .act_flat_w   (act_flat_w),
  .pend_flat_w  (pend_flat_w)
);

// File: tb/pcm_slot_assigner_bench.sv
module pcm_slot_assigner_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fsync;
  logic       cclk;
  logic       cdata;
  logic       csel_n;
  logic [1:0] chsel;
  logic [3:0] tx_fs;
  logic [3:0] rx_fs;
  logic       busy_n;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #10 clk = ~clk;

  pcm_slot_assigner u_pcm_slot_assigner (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_sync_i (fsync),
    .ctl_clk_i    (cclk),
    .ctl_data_i   (cdata),
    .ctl_sel_n_i  (csel_n),
    .chan_sel_i   (chsel),
    .tx_fs_o      (tx_fs),
    .rx_fs_o      (rx_fs),
    .tx_busy_n_o  (busy_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference, one step per clock ----------------
  int m_bit, m_slot;
  bit m_run;
  bit m_pv[2][4];
  int m_ps[2][4];
  bit m_av[2][4];
  int m_as[2][4];
  int m_word, m_n;
  bit m_cprev, m_sprev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bit = 0; m_slot = 0; m_run = 0; m_word = 0; m_n = 0;
      m_cprev = 0; m_sprev = 1;
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 4; c++) begin
          m_pv[d][c] = 0; m_ps[d][c] = 0; m_av[d][c] = 0; m_as[d][c] = 0;
        end
    end else begin
      if (fsync) begin
        m_av = m_pv; m_as = m_ps;
        m_run = 1; m_slot = 0; m_bit = 0;
      end else if (m_run) begin
        if (m_bit == 7) begin
          m_bit = 0;
          if (m_slot == 63) m_run = 0; else m_slot++;
        end else m_bit++;
      end
      if (cclk && !m_cprev && !csel_n) begin
        m_word = ((m_word << 1) | int'(cdata)) & 8'hFF;
        if (m_n < 9) m_n++;
      end
      if (csel_n && !m_sprev && m_n == 8) begin
        m_pv[(m_word >> 7) & 1][chsel] = bit'((m_word >> 6) & 1);
        m_ps[(m_word >> 7) & 1][chsel] = m_word & 63;
      end
      if (csel_n) m_n = 0;
      m_cprev = cclk;
      m_sprev = csel_n;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      logic [3:0] etx, erx;
      for (int c = 0; c < 4; c++) begin
        etx[c] = m_run && m_av[0][c] && (m_as[0][c] == m_slot);
        erx[c] = m_run && m_av[1][c] && (m_as[1][c] == m_slot);
      end
      check({tx_fs, rx_fs} == {etx, erx}, "R4 strobes vs model", {tx_fs, rx_fs}, {etx, erx});
      check(busy_n == ~|etx, "R6 busy vs model", busy_n, ~|etx);
    end
  end

  // ---------------- intent of the directed tests ----------------
  bit b_pv[2][4];
  int b_ps[2][4];
  bit b_av[2][4];
  int b_as[2][4];

  task automatic send_bits(input int dir, input bit en, input int slot,
                           input int ch, input int nbits);
    logic [7:0] w;
    w = {dir[0], en, slot[5:0]};
    @(negedge clk) csel_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      cdata = (k < 8) ? w[7-k] : 1'b0;
      @(negedge clk) cclk = 1'b1;
      @(negedge clk) cclk = 1'b0;
    end
    chsel = ch[1:0];
    @(negedge clk) csel_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (nbits == 8) begin
      b_pv[dir][ch] = en;
      b_ps[dir][ch] = slot;
    end
  endtask

  task automatic stray_clocks(input int ch);
    chsel = ch[1:0];
    for (int k = 0; k < 8; k++) begin
      cdata = k[0];
      @(negedge clk) cclk = 1'b1;
      @(negedge clk) cclk = 1'b0;
    end
    @(negedge clk) csel_n = 1'b0;
    @(negedge clk) csel_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_frame(input string name);
    int cnt[2][4];
    int first[2][4];
    int busy_cnt;
    bit used[64];
    int nused;
    bit quiet;
    busy_cnt = 0;
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 4; c++) begin cnt[d][c] = 0; first[d][c] = -1; end
    @(negedge clk) fsync = 1'b1;
    b_av = b_pv; b_as = b_ps;
    @(negedge clk) fsync = 1'b0;
    for (int i = 0; i < 512; i++) begin
      for (int c = 0; c < 4; c++) begin
        if (tx_fs[c]) begin if (cnt[0][c] == 0) first[0][c] = i; cnt[0][c]++; end
        if (rx_fs[c]) begin if (cnt[1][c] == 0) first[1][c] = i; cnt[1][c]++; end
      end
      if (!busy_n) busy_cnt++;
      @(negedge clk);
    end
    quiet = 1;
    for (int i = 0; i < 16; i++) begin
      if (tx_fs != 0 || rx_fs != 0 || !busy_n) quiet = 0;
      @(negedge clk);
    end
    check(quiet, {name, " R9 quiet after slot 63"}, int'(quiet), 1);
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 4; c++) begin
        if (b_av[d][c]) begin
          check(cnt[d][c] == 8, {name, " R4 strobe length"}, cnt[d][c], 8);
          check(first[d][c] == b_as[d][c] * 8, {name, " R1 strobe position"},
                first[d][c], b_as[d][c] * 8);
        end else begin
          check(cnt[d][c] == 0, {name, " R10 disabled strobe silent"}, cnt[d][c], 0);
        end
      end
    nused = 0;
    for (int s = 0; s < 64; s++) used[s] = 0;
    for (int c = 0; c < 4; c++) if (b_av[0][c]) used[b_as[0][c]] = 1;
    for (int s = 0; s < 64; s++) if (used[s]) nused++;
    check(busy_cnt == nused * 8, {name, " R6 busy low cycles"}, busy_cnt, nused * 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 4; c++) begin
        b_pv[d][c] = 0; b_ps[d][c] = 0; b_av[d][c] = 0; b_as[d][c] = 0;
      end
    rst_n = 1'b0; fsync = 1'b0; cclk = 1'b0; cdata = 1'b0; csel_n = 1'b1; chsel = 2'd0;
    repeat (4) @(negedge clk);
    check(tx_fs == 4'd0 && rx_fs == 4'd0, "R8 strobes low in reset", {tx_fs, rx_fs}, 0);
    check(busy_n == 1'b1, "R8 busy high in reset", busy_n, 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(tx_fs == 4'd0 && rx_fs == 4'd0 && busy_n, "R9 no strobe before first sync",
          {tx_fs, rx_fs, busy_n}, 1);

    run_frame("reset-state frame R8");

    // R2 R5: mixed assignments, one direction only on some channels
    send_bits(0, 1, 3, 0, 8);
    send_bits(1, 0, 3, 0, 8);
    send_bits(1, 1, 10, 1, 8);
    send_bits(0, 1, 63, 2, 8);
    send_bits(0, 1, 0, 3, 8);
    send_bits(1, 1, 0, 3, 8);
    run_frame("R2 R5 mixed");

    // R7: reload ch1 receive while a frame runs; old slot 10 holds this frame
    fork
      run_frame("R7 frame with reload");
      begin
        @(negedge clk);
        send_bits(1, 1, 2, 1, 8);
      end
    join
    run_frame("R7 next frame");

    // R3: short, long and unselected words leave assignments unchanged
    send_bits(0, 1, 5, 0, 7);
    send_bits(1, 1, 40, 2, 9);
    stray_clocks(3);
    run_frame("R3 rejected words");

    // R10 and R6: disable ch3 transmit, two channels share slot 20
    send_bits(0, 0, 0, 3, 8);
    send_bits(0, 1, 20, 0, 8);
    send_bits(0, 1, 20, 1, 8);
    run_frame("R10 R6 shared slot");

    // R9: long gap without sync
    repeat (100) @(negedge clk);
    check(tx_fs == 4'd0 && rx_fs == 4'd0, "R9 idle gap", {tx_fs, rx_fs}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule